// File: doc/BRIEF.md
# Flash Page Buffer Operation Engine

This block carries out page-level commands against a small modelled flash main memory and a pair of page buffers. After a one-cycle launch it can copy a main-memory page into a chosen buffer, compare a main-memory page with a chosen buffer one byte at a time, or refresh a page. A refresh copies the page into a buffer and then writes that buffer back into the same page. The caller supplies the command, the buffer choice, a page number and a page-size mode. Status is read from an 8-bit word: bit 7 shows whether the engine is ready, and bit 6 holds the outcome of the last compare.

The engine handles one byte per clock. A refresh adds a parameterised settle delay after its write-back, which stands in for the cell programming time. The memory model has a small power-of-two page count, and the upper bits of the requested page number are dropped. Both arrays start from fixed arithmetic patterns on reset, so each command has a visible effect that later compares can detect.

Top module: `pgbuf_engine`

## Requirements
- R1: While reset is asserted and just after it, `status` reads 8'h80. Main-memory byte i of page p is (37*p + 5*i + 1) mod 256. Byte i of buffer b is (100*b + 3*i + 90) mod 256, where b = 0 is the buffer chosen by `buf_sel`=0 and b = 1 is the buffer chosen by `buf_sel`=1.
- R2: An operation covers byte indices 0 to 255 when `bin_mode`=1 and 0 to 263 when `bin_mode`=0. Bytes outside that range take no part.
- R3: `op`=2'd0 (fetch) copies each covered byte of the addressed page into the same index of the selected buffer. The other buffer does not change, and neither does any uncovered byte.
- R4: `op`=2'd1 (check) writes 0 to status bit 6 when every covered byte of the page equals the selected buffer's byte at the same index, and writes 1 otherwise. Bit 6 changes only in the cycle in which the engine becomes ready again.
- R5: `op`=2'd2 (refresh) first performs a fetch. It then writes the selected buffer's covered bytes back into the same page, so the page keeps its contents and the buffer ends up equal to it.
- R6: Status bit 7 is 0 from the cycle after an accepted launch. It stays 0 for N cycles for fetch and check, and for 2N + SETTLE_CYC cycles for refresh, where N is the covered byte count.
- R7: A launch is ignored while bit 7 is 0, and a launch with `op`=2'd3 is ignored at all times. An ignored launch leaves both status bits unchanged and does not make the engine busy.
- R8: The page actually used is `page` modulo PAGES, that is, its low log2(PAGES) bits.
- R9: Fetch and refresh leave status bit 6 unchanged.
- R10: Status bits 5 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch | input | 1 | One-cycle start request |
| op | input | 2 | Command: 0 fetch, 1 check, 2 refresh, 3 reserved |
| buf_sel | input | 1 | Buffer choice: 0 first, 1 second |
| page | input | PAGE_IN_W (12) | Requested page number |
| bin_mode | input | 1 | 1: 256-byte pages, 0: 264-byte pages |
| status | output | 8 | Bit 7 ready, bit 6 compare mismatch, bits 5..0 zero |

## Verification
Two events can land on the same clock edge: the final byte step of a running operation, and a new launch request. The final step is also the edge on which bit 6 may change. The bench raises a check launch exactly on the last busy cycle of a fetch. It then expects the engine to be ready on the following cycle with bit 6 untouched, which shows that the request was dropped and not queued or started late. A launch placed on the first ready cycle after another operation must start normally. Its busy span is counted, and the compare results come from a bench-side copy of both arrays.

// File: rtl/pgbuf_pkg.sv
// Shared types and reset patterns for the page buffer engine.
// Assumes 8-bit data bytes.
package pgbuf_pkg;

    typedef enum logic [1:0] {
        OP_FETCH   = 2'd0,
        OP_CHECK   = 2'd1,
        OP_REFRESH = 2'd2,
        OP_NONE    = 2'd3
    } pg_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_WRITEBACK,
        ST_SETTLE
    } pg_state_e;

    // Reset content of main-memory byte i of page p
    function automatic logic [7:0] main_seed(input int p, input int i);
        return 8'(37 * p + 5 * i + 1);
    endfunction

    // Reset content of byte i of buffer b
    function automatic logic [7:0] buf_seed(input int b, input int i);
        return 8'(100 * b + 3 * i + 90);
    endfunction

endpackage

// File: rtl/pgbuf_main_store.sv
// Main memory model: PAGES pages of PAGE_MAX bytes, flat array.
// One combinational read and one synchronous write at the same address.
// Assumes the array is small enough to be reset-loaded as flops.
module pgbuf_main_store
    import pgbuf_pkg::*;
#(
    parameter int PAGES    = 4,
    parameter int PAGE_MAX = 264,
    parameter int PG_W     = 2,
    parameter int IDX_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PG_W-1:0]  pg,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data
);
    localparam int DEPTH = PAGES * PAGE_MAX;
    localparam int AW    = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] addr;

    // Flat address of the selected byte
    assign addr    = AW'(pg) * AW'(PAGE_MAX) + AW'(idx);
    assign rd_data = mem[addr];

    // Load seed pattern on reset, otherwise take write-back bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PAGES; p++)
                for (int i = 0; i < PAGE_MAX; i++)
                    mem[AW'(p * PAGE_MAX + i)] <= main_seed(p, i);
        end else if (wr_en) begin
            mem[addr] <= wr_data;
        end
    end
endmodule

// File: rtl/pgbuf_buffer_pair.sv
// Two page buffers of PAGE_MAX bytes. The selected bank is read
// combinationally and written synchronously at the shared index.
module pgbuf_buffer_pair
    import pgbuf_pkg::*;
#(
    parameter int PAGE_MAX = 264,
    parameter int IDX_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data
);
    logic [7:0] rd_each [2];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [7:0] bank [PAGE_MAX];

        // Seed on reset, write only when this bank is selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < PAGE_MAX; i++)
                    bank[i] <= buf_seed(g, i);
            end else if (wr_en && sel == 1'(g)) begin
                bank[idx] <= wr_data;
            end
        end

        assign rd_each[g] = bank[idx];
    end

    assign rd_data = rd_each[sel];
endmodule

// File: rtl/pgbuf_sequencer.sv
// Command sequencer: accepts a launch when idle, steps one byte per
// cycle, runs the refresh write-back and settle delay, and keeps the
// status word. Assumes PAGES is a power of two.
module pgbuf_sequencer
    import pgbuf_pkg::*;
#(
    parameter int PAGE_IN_W  = 12,
    parameter int PG_W       = 2,
    parameter int IDX_W      = 9,
    parameter int PAGE_STD   = 264,
    parameter int PAGE_BIN   = 256,
    parameter int SETTLE_CYC = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic [1:0]           op,
    input  logic                 buf_sel,
    input  logic [PAGE_IN_W-1:0] page,
    input  logic                 bin_mode,
    input  logic [7:0]           mem_rd,
    input  logic [7:0]           buf_rd,
    output logic [PG_W-1:0]      pg_q,
    output logic                 sel_q,
    output logic [IDX_W-1:0]     idx_q,
    output logic                 mem_we,
    output logic                 buf_we,
    output logic [7:0]           status
);
    localparam int WAIT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

    pg_state_e         state;
    logic [IDX_W-1:0]  last_q;
    logic              refresh_q;
    logic              miss_q;
    logic              cmp_q;
    logic [WAIT_W-1:0] wait_q;
    logic              accept;
    logic              at_last;
    logic              differ;
    logic              unused_page_hi;

    assign unused_page_hi = ^page;
    assign accept  = launch && state == ST_IDLE && pg_op_e'(op) != OP_NONE;
    assign at_last = idx_q == last_q;
    assign differ  = mem_rd != buf_rd;
    assign mem_we  = state == ST_WRITEBACK;
    assign buf_we  = state == ST_FETCH;
    assign status  = {state == ST_IDLE, cmp_q, 6'b0};

    // Command state machine and byte stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pg_q      <= '0;
            sel_q     <= 1'b0;
            idx_q     <= '0;
            last_q    <= '0;
            refresh_q <= 1'b0;
            miss_q    <= 1'b0;
            cmp_q     <= 1'b0;
            wait_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    pg_q      <= page[PG_W-1:0];
                    sel_q     <= buf_sel;
                    idx_q     <= '0;
                    last_q    <= bin_mode ? IDX_W'(PAGE_BIN - 1) : IDX_W'(PAGE_STD - 1);
                    refresh_q <= pg_op_e'(op) == OP_REFRESH;
                    miss_q    <= 1'b0;
                    state     <= (pg_op_e'(op) == OP_CHECK) ? ST_CHECK : ST_FETCH;
                end
                ST_FETCH: begin
                    idx_q <= idx_q + 1'b1;
                    if (at_last) begin
                        idx_q <= '0;
                        state <= refresh_q ? ST_WRITEBACK : ST_IDLE;
                    end
                end
                ST_CHECK: begin
                    idx_q  <= idx_q + 1'b1;
                    miss_q <= miss_q | differ;
                    if (at_last) begin
                        cmp_q <= miss_q | differ;
                        state <= ST_IDLE;
                    end
                end
                ST_WRITEBACK: begin
                    idx_q <= idx_q + 1'b1;
                    if (at_last) begin
                        idx_q  <= '0;
                        wait_q <= '0;
                        state  <= (SETTLE_CYC == 0) ? ST_IDLE : ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    wait_q <= wait_q + 1'b1;
                    if (wait_q == WAIT_W'(SETTLE_CYC - 1))
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgbuf_engine.sv
// Top of the page buffer operation engine: sequencer, main memory
// model and buffer pair. PAGES must be a power of two.
module pgbuf_engine
    import pgbuf_pkg::*;
#(
    parameter int PAGES      = 4,
    parameter int PAGE_IN_W  = 12,
    parameter int PAGE_STD   = 264,
    parameter int PAGE_BIN   = 256,
    parameter int SETTLE_CYC = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic [1:0]           op,
    input  logic                 buf_sel,
    input  logic [PAGE_IN_W-1:0] page,
    input  logic                 bin_mode,
    output logic [7:0]           status
);
    localparam int PG_W  = (PAGES > 1) ? $clog2(PAGES) : 1;
    localparam int IDX_W = $clog2(PAGE_STD);

    logic [PG_W-1:0]  pg_q;
    logic             sel_q;
    logic [IDX_W-1:0] idx_q;
    logic             mem_we;
    logic             buf_we;
    logic [7:0]       mem_rd;
    logic [7:0]       buf_rd;

    pgbuf_sequencer #(
        .PAGE_IN_W (PAGE_IN_W),
        .PG_W      (PG_W),
        .IDX_W     (IDX_W),
        .PAGE_STD  (PAGE_STD),
        .PAGE_BIN  (PAGE_BIN),
        .SETTLE_CYC(SETTLE_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .op      (op),
        .buf_sel (buf_sel),
        .page    (page),
        .bin_mode(bin_mode),
        .mem_rd  (mem_rd),
        .buf_rd  (buf_rd),
        .pg_q    (pg_q),
        .sel_q   (sel_q),
        .idx_q   (idx_q),
        .mem_we  (mem_we),
        .buf_we  (buf_we),
        .status  (status)
    );

    pgbuf_main_store #(
        .PAGES   (PAGES),
        .PAGE_MAX(PAGE_STD),
        .PG_W    (PG_W),
        .IDX_W   (IDX_W)
    ) u_main (
        .clk    (clk),
        .rst_n  (rst_n),
        .pg     (pg_q),
        .idx    (idx_q),
        .wr_en  (mem_we),
        .wr_data(buf_rd),
        .rd_data(mem_rd)
    );

    pgbuf_buffer_pair #(
        .PAGE_MAX(PAGE_STD),
        .IDX_W   (IDX_W)
    ) u_bufs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel_q),
        .idx    (idx_q),
        .wr_en  (buf_we),
        .wr_data(mem_rd),
        .rd_data(buf_rd)
    );
endmodule

// File: rtl/pgbuf_checker.sv
// Port-level protocol checks for pgbuf_engine, attached by bind.
module pgbuf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       launch,
    input logic [1:0] op,
    input logic [7:0] status
);
    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[5:0] == 6'b0); // R10

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && status[7] && op != 2'd3) |=> !status[7]); // R6

    AST_RESERVED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && status[7] && op == 2'd3) |=> (status[7] && $stable(status[6]))); // R7

    AST_FLAG_MOVES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status[6]) |-> $rose(status[7])); // R4

    AST_BUSY_MIN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[7]) |=> !status[7]); // R6
endmodule

bind pgbuf_engine pgbuf_checker u_pgbuf_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .launch(launch),
    .op    (op),
    .status(status)
);

// File: tb/test_pgbuf_engine.sv
`timescale 1ns/1ps
module test_pgbuf_engine;
    localparam int PAGES  = 4;
    localparam int STD_N  = 264;
    localparam int BIN_N  = 256;
    localparam int SETTLE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       launch = 1'b0;
    logic [1:0] op = 2'd0;
    logic       buf_sel = 1'b0;
    logic [11:0] page = '0;
    logic       bin_mode = 1'b0;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    int exp_cmp = 0;
    logic [7:0] mm [PAGES][STD_N];
    logic [7:0] bf [2][STD_N];

    always #2 clk = ~clk;

    pgbuf_engine i_pgbuf_engine (
        .clk(clk), .rst_n(rst_n), .launch(launch), .op(op),
        .buf_sel(buf_sel), .page(page), .bin_mode(bin_mode), .status(status)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int miss_model(input int p, input int b, input int n);
        for (int i = 0; i < n; i++)
            if (mm[p][i] != bf[b][i]) return 1;
        return 0;
    endfunction

    // Drive one launch and count the busy cycles that follow
    task automatic run_op(input int o, input int b, input int pg_in, input int md,
                          output int cyc);
        @(negedge clk);
        launch = 1'b1; op = 2'(o); buf_sel = 1'(b); page = 12'(pg_in); bin_mode = 1'(md);
        @(negedge clk);
        launch = 1'b0;
        cyc = 0;
        while (status[7] == 1'b0 && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic do_check(input int p, input int b, input int md, input string req);
        int cyc;
        int n;
        n = md ? BIN_N : STD_N;
        run_op(1, b, p, md, cyc);
        check({req, " R6 check span"}, cyc, n);
        exp_cmp = miss_model(p, b, n);
        check({req, " R4 compare bit"}, int'(status[6]), exp_cmp);
    endtask

    task automatic do_fetch(input int pg_in, input int b, input int md, input int refresh);
        int cyc;
        int n;
        int p;
        n = md ? BIN_N : STD_N;
        p = pg_in % PAGES;
        run_op(refresh ? 2 : 0, b, pg_in, md, cyc);
        check(refresh ? "R5 R6 refresh span" : "R3 R6 fetch span",
              cyc, refresh ? 2 * n + SETTLE : n);
        check("R9 bit6 kept", int'(status[6]), exp_cmp);
        for (int i = 0; i < n; i++) bf[b][i] = mm[p][i];
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        for (int p = 0; p < PAGES; p++)
            for (int i = 0; i < STD_N; i++) mm[p][i] = 8'(37 * p + 5 * i + 1);
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < STD_N; i++) bf[b][i] = 8'(100 * b + 3 * i + 90);

        repeat (3) @(negedge clk);
        check("R1 status in reset", int'(status), 8'h80);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 R10 status after reset", int'(status), 8'h80);

        // Sweep all compares on the seed contents
        for (int md = 0; md < 2; md++)
            for (int p = 0; p < PAGES; p++)
                for (int b = 0; b < 2; b++)
                    do_check(p, b, md, "R1 seed");

        // Binary fetch with out-of-range page numbers, then compares
        for (int b = 0; b < 2; b++)
            for (int p = 0; p < PAGES; p++) begin
                do_fetch(p + PAGES * (p + 1), b, 1, 0);   // R8 truncation
                do_check(p, b, 1, "R3 R8 binary match");
                check("R3 match after fetch", int'(status[6]), 0);
                do_check(p, b, 0, "R2 tail untouched");
                check("R2 tail mismatch", int'(status[6]), 1);
                do_check((p + 1) % PAGES, b, 1, "R3 other page");
                do_check(p, 1 - b, 0, "R3 other buffer");
            end

        // Standard-size fetch
        do_fetch(2, 1, 0, 0);
        do_check(2, 1, 0, "R2 standard match");
        check("R2 standard full match", int'(status[6]), 0);

        // Refresh of every page, alternating sizes
        for (int p = 0; p < PAGES; p++)
            for (int b = 0; b < 2; b++) begin
                do_check(p, b, 0, "R5 before");
                do_fetch(p, b, p % 2, 1);
                do_check(p, b, p % 2, "R5 buffer equals page");
                check("R5 refresh match", int'(status[6]), 0);
                do_check(p, 1 - b, 0, "R5 page intact");
            end

        // Launch on the last busy cycle is dropped
        do_check(0, 0, 0, "R7 setup");
        @(negedge clk);
        launch = 1'b1; op = 2'd0; buf_sel = 1'b1; page = 12'd3; bin_mode = 1'b1;
        @(negedge clk);
        launch = 1'b0;
        repeat (BIN_N - 1) @(negedge clk);
        check("R6 busy at last byte", int'(status[7]), 0);
        launch = 1'b1; op = 2'd1; buf_sel = 1'b0; page = 12'd1;
        @(negedge clk);
        launch = 1'b0;
        check("R7 launch while busy dropped", int'(status[7]), 1);
        check("R7 bit6 unchanged", int'(status[6]), exp_cmp);
        for (int i = 0; i < BIN_N; i++) bf[1][i] = mm[3][i];
        do_check(3, 1, 1, "R7 fetch completed");

        // Reserved command ignored
        @(negedge clk);
        launch = 1'b1; op = 2'd3;
        @(negedge clk);
        launch = 1'b0;
        check("R7 reserved op stays ready", int'(status[7]), 1);
        check("R7 reserved op bit6", int'(status[6]), exp_cmp);
        check("R10 low bits", int'(status[5:0]), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule